// File: doc/BRIEF.md
# Reset-Latched Endian Byte-Lane Adapter

This block sits between the load/store port of a 32-bit processor and a byte-addressed memory bus whose byte lane k always carries the byte at word offset k. It turns each processor request into a word-aligned bus request. It steers write data onto the right byte lanes, raises the matching byte strobes, and pulls read data back out of the lanes. The result is right-justified in the 32-bit return value.

A single endian mode is taken from a select input while reset is held, and stays fixed until the next reset. In big-endian mode, the bytes of a halfword or word are mirrored: the most significant byte of the value goes to the lowest address. Single bytes land on the lane of their own address in either mode. Two kinds of access ignore the big-endian mode and always use the little-endian layout:
- instruction fetches;
- any access inside a fixed 4 KB control window.

Misaligned halfword and word requests are not forwarded. They raise an error output instead. The whole datapath is combinational, and read data is taken from the bus in the same cycle as the request.

Top module: `endian_lane_adapter`

## Requirements
- R1: The endian mode is taken from `big_end_sel` on each clock edge while `rst_n` is low. After reset is released, changes on `big_end_sel` have no effect until the next reset. A value of 1 selects big-endian.
- R2: Little-endian data layout, for a request that is forwarded:
  - A value of N bytes (N = 1, 2 or 4) at word offset o places value byte i (byte 0 = bits [7:0]) on lane o+i of `bus_wdata`.
  - Write-data lanes that are not strobed are zero, and all of `bus_wdata` is zero on reads.
- R3: Big-endian data layout, for a request that is forwarded:
  - Value byte N-1-i goes to lane o+i, so the most significant byte of a word sits in lane 0.
  - A single byte still uses lane o.
- R4: A request with `req_fetch` high always uses the little-endian layout, whatever the mode.
- R5: A request whose address lies in 0xE000E000..0xE000EFFF always uses the little-endian layout. Addresses just outside that window follow the mode.
- R6: Byte strobes of a forwarded request are set for exactly lanes o..o+N-1. They are all zero when nothing is forwarded.
- R7: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. The following valid requests raise `req_misalign` and are not forwarded (`bus_valid` = 0, strobes 0):
  - a halfword with address bit 0 set;
  - a word with a nonzero address[1:0];
  - size 3.
- R8: On a read, `req_rdata` holds the byte or halfword from the lanes given by R2/R3/R4/R5, right-justified and zero-extended.
- R9: A forwarded request drives `bus_valid` = 1, sets `bus_write` equal to `req_write`, and sets `bus_addr` to the request address with bits [1:0] cleared.
- R10: After reset with no request (`req_valid` = 0), the outputs `bus_valid`, `bus_write`, `req_misalign` and `bus_strb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; mode is captured while low |
| big_end_sel | input | 1 | Endian select, 1 = big-endian |
| req_valid | input | 1 | Processor request present |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Right-justified write value |
| req_rdata | output | 32 | Right-justified, zero-extended read value |
| req_misalign | output | 1 | Alignment error, request dropped |
| bus_valid | output | 1 | Bus request present |
| bus_write | output | 1 | Bus write |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_strb | output | 4 | Byte-lane strobes, bit k = lane k |
| bus_wdata | output | 32 | Lane-ordered write data |
| bus_rdata | input | 32 | Lane-ordered read data |

## Verification
The only state is the captured endian mode, so any corruption of it shows up at once, on the next halfword or word data access outside the exempt cases. A corrupted mode makes `bus_wdata` or `req_rdata` come out byte-reversed while the strobes stay correct. Fetches and accesses in the control window mask a wrong mode, which is why the bench mixes exempt and non-exempt addresses near the window edges. A mode that follows `big_end_sel` after reset is caught in the first access after that input toggles.

// File: rtl/endian_lane_adapter.sv
module endian_lane_adapter #(
  parameter logic [31:0] CTRL_BASE      = 32'hE000E000,
  parameter int          CTRL_SPAN_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_end_sel,
  input  logic        req_valid,
  input  logic        req_fetch,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] req_rdata,
  output logic        req_misalign,
  output logic        bus_valid,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [3:0]  bus_strb,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic mode_q;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= big_end_sel;

  function automatic logic [31:0] rev4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [1:0]  off;
  logic        in_ctrl, swap, bad, fwd;
  logic [31:0] prep, rsh;
  logic [3:0]  base_strb;

  assign off     = req_addr[1:0];
  assign in_ctrl = req_addr[31:CTRL_SPAN_LOG2] == CTRL_BASE[31:CTRL_SPAN_LOG2];
  assign swap    = mode_q & ~req_fetch & ~in_ctrl;

  assign bad = (req_size == SZ_HALF && off[0]) ||
               (req_size == SZ_WORD && off != 2'd0) ||
               (req_size == 2'd3);
  assign fwd = req_valid & ~bad;

  assign req_misalign = req_valid & bad;
  assign bus_valid    = fwd;
  assign bus_write    = fwd & req_write;
  assign bus_addr     = {req_addr[31:2], 2'b00};

  always_comb begin
    case (req_size)
      SZ_BYTE: begin
        base_strb = 4'b0001;
        prep      = {24'd0, req_wdata[7:0]};
      end
      SZ_HALF: begin
        base_strb = 4'b0011;
        prep      = swap ? {16'd0, req_wdata[7:0], req_wdata[15:8]}
                         : {16'd0, req_wdata[15:0]};
      end
      default: begin
        base_strb = 4'b1111;
        prep      = swap ? rev4(req_wdata) : req_wdata;
      end
    endcase
  end

  assign bus_strb  = fwd ? (base_strb << off) : 4'd0;
  assign bus_wdata = (fwd & req_write) ? (prep << {off, 3'b000}) : 32'd0;

  assign rsh = bus_rdata >> {off, 3'b000};

  always_comb begin
    case (req_size)
      SZ_BYTE: req_rdata = {24'd0, rsh[7:0]};
      SZ_HALF: req_rdata = swap ? {16'd0, rsh[7:0], rsh[15:8]} : {16'd0, rsh[15:0]};
      default: req_rdata = swap ? rev4(rsh) : rsh;
    endcase
  end

endmodule

// File: rtl/endian_lane_adapter_chk.sv
module endian_lane_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_q,
  input logic        req_valid,
  input logic        req_fetch,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [31:0] req_addr,
  input logic [31:0] req_rdata,
  input logic        req_misalign,
  input logic        bus_valid,
  input logic [3:0]  bus_strb,
  input logic [31:0] bus_rdata
);

  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  a_r6_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_strb) == (32'd1 << req_size)));

  a_r7_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_misalign |-> (!bus_valid && bus_strb == 4'd0));

  a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (bus_valid != req_misalign));

  a_r4_fetch_word_le: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_fetch && !req_write && req_size == 2'd2) |-> (req_rdata == bus_rdata));

  a_r5_ctrl_word_le: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !req_write && req_size == 2'd2 && req_addr[31:12] == 20'hE000E)
      |-> (req_rdata == bus_rdata));

  a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_size == 2'd0) |-> (req_rdata[31:8] == 24'd0));

endmodule

bind endian_lane_adapter endian_lane_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .req_valid(req_valid),
  .req_fetch(req_fetch), .req_write(req_write), .req_size(req_size),
  .req_addr(req_addr), .req_rdata(req_rdata), .req_misalign(req_misalign),
  .bus_valid(bus_valid), .bus_strb(bus_strb), .bus_rdata(bus_rdata)
);

// File: tb/endian_lane_adapter_bench.sv
module endian_lane_adapter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_end_sel = 1'b0;
  logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0, req_wdata = 32'd0, bus_rdata = 32'd0;
  logic [31:0] req_rdata, bus_addr, bus_wdata;
  logic        req_misalign, bus_valid, bus_write;
  logic [3:0]  bus_strb;

  int total = 0, bad = 0;
  logic exp_mode;

  always #2 clk = ~clk;

  endian_lane_adapter u_endian_lane_adapter (
    .clk(clk), .rst_n(rst_n), .big_end_sel(big_end_sel), .req_valid(req_valid),
    .req_fetch(req_fetch), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .req_misalign(req_misalign), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h addr=%h size=%0d", tag, got, exp, req_addr, req_size);
    end
  endtask

  function automatic logic mirrored(input logic [31:0] a, input logic f);
    return exp_mode && !f && !(a >= 32'hE000E000 && a < 32'hE000F000);
  endfunction

  function automatic logic misfit(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'd3) return 1'b1;
    return (int'(o) % (1 << sz)) != 0;
  endfunction

  task automatic do_reset(input logic sel);
    rst_n = 1'b0;
    req_valid = 1'b0;
    big_end_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_mode = sel;
    @(negedge clk);
    #1;
    check("R10 idle bus_valid", {31'd0, bus_valid}, 32'd0);
    check("R10 idle bus_write", {31'd0, bus_write}, 32'd0);
    check("R10 idle misalign", {31'd0, req_misalign}, 32'd0);
    check("R10 idle strb", {28'd0, bus_strb}, 32'd0);
  endtask

  task automatic access(input logic f, input logic w, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] d, input logic [31:0] br);
    logic [31:0] ew, er;
    logic [3:0]  es;
    logic        sw, mis;
    int n, o;
    @(negedge clk);
    req_valid = 1'b1; req_fetch = f; req_write = w; req_size = sz;
    req_addr = a; req_wdata = d; bus_rdata = br;
    #1;
    mis = misfit(sz, a[1:0]);
    check("R7 misalign", {31'd0, req_misalign}, {31'd0, mis});
    check("R9 bus_valid", {31'd0, bus_valid}, {31'd0, !mis});
    if (mis) begin
      check("R6 strb dropped", {28'd0, bus_strb}, 32'd0);
    end else begin
      sw = mirrored(a, f);
      n = 1 << sz;
      o = int'(a[1:0]);
      ew = 32'd0; er = 32'd0; es = 4'd0;
      for (int i = 0; i < n; i++) begin
        int src;
        src = sw ? (n - 1 - i) : i;
        es[o+i] = 1'b1;
        ew[(o+i)*8 +: 8] = d[src*8 +: 8];
        er[src*8 +: 8]   = br[(o+i)*8 +: 8];
      end
      check("R6 strb", {28'd0, bus_strb}, {28'd0, es});
      check("R9 bus_addr", bus_addr, {a[31:2], 2'b00});
      check("R9 bus_write", {31'd0, bus_write}, {31'd0, w});
      if (w) check(sw ? "R3 wdata" : "R2 wdata", bus_wdata, ew);
      else begin
        check("R2 rd wdata zero", bus_wdata, 32'd0);
        check(sw ? "R3 R8 rdata" : "R8 rdata", req_rdata, er);
      end
    end
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    logic [31:0] r;
    r = $urandom;
    case (k % 5)
      0: return 32'hE000E000 | (r & 32'h0000_0FFF);
      1: return 32'hE000DFFC | (r & 32'h3);
      2: return 32'hE000F000 | (r & 32'h3);
      3: return 32'hE000EFFC | (r & 32'h3);
      default: return r;
    endcase
  endfunction

  task automatic run_random(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      logic [1:0] sz;
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      access(1'($urandom), 1'($urandom), sz, pick_addr(int'($urandom % 16)), $urandom, $urandom);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    do_reset(1'b1);
    access(1'b0, 1'b1, 2'd2, 32'h2000_0000, 32'h1234_5678, 32'd0);
    check("R3 word msb lane0", bus_wdata, 32'h7856_3412);
    access(1'b0, 1'b0, 2'd1, 32'h2000_0002, 32'd0, 32'hAABB_CCDD);
    check("R3 R8 half rd", req_rdata, 32'h0000_BBAA);
    access(1'b0, 1'b1, 2'd0, 32'h2000_0003, 32'h0000_00E7, 32'd0);
    check("R3 byte lane", bus_wdata, 32'hE700_0000);
    access(1'b1, 1'b0, 2'd2, 32'h2000_0000, 32'd0, 32'h0102_0304);
    check("R4 fetch le", req_rdata, 32'h0102_0304);
    access(1'b0, 1'b0, 2'd2, 32'hE000E010, 32'd0, 32'h0A0B_0C0D);
    check("R5 ctrl le", req_rdata, 32'h0A0B_0C0D);
    access(1'b0, 1'b0, 2'd2, 32'hE000F000, 32'd0, 32'h0A0B_0C0D);
    check("R5 past ctrl swaps", req_rdata, 32'h0D0C_0B0A);
    big_end_sel = 1'b0;
    access(1'b0, 1'b0, 2'd2, 32'h3000_0000, 32'd0, 32'h1122_3344);
    check("R1 mode held big", req_rdata, 32'h4433_2211);
    access(1'b0, 1'b0, 2'd2, 32'h3000_0002, 32'd0, 32'd0);
    access(1'b0, 1'b1, 2'd1, 32'h3000_0001, 32'd0, 32'd0);
    access(1'b0, 1'b0, 2'd3, 32'h3000_0000, 32'd0, 32'd0);
    run_random(600);

    do_reset(1'b0);
    big_end_sel = 1'b1;
    access(1'b0, 1'b1, 2'd1, 32'h4000_0002, 32'h0000_BEEF, 32'd0);
    check("R1 R2 mode held little", bus_wdata, 32'hBEEF_0000);
    check("R6 half off2", {28'd0, bus_strb}, 32'h0000_000C);
    access(1'b0, 1'b0, 2'd0, 32'h4000_0001, 32'd0, 32'h0000_9A00);
    check("R8 byte zext", req_rdata, 32'h0000_009A);
    run_random(600);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule